// File: doc/BRIEF.md
# Programmable Square-Wave Output Selector

This block produces the square-wave output of a real-time clock. A 15-stage binary divider, driven by a clock that runs at twice the 32.768 kHz oscillator rate, supplies every frequency. Divider stage 0 toggles once per clock cycle, so it is the 32.768 kHz signal itself. Stage k is 32768 / 2^k Hz. A 4-bit rate code picks one of 13 stages as the programmable tap. A separate fast-clock enable replaces the programmed tap with the 32.768 kHz signal.

The block holds two control bits. One is the oscillator-on bit, which lets the divider run. The other is the fast-clock enable. Both are loaded through a write strobe, and both are forced to 1 by a power-up event, so the 32.768 kHz output appears as soon as power comes up. When the main supply is below its fail threshold, the output keeps running only in one case: the fast-clock enable is set, the auxiliary battery is enabled and the auxiliary supply is present. In every other case it is driven low. The output is registered, so it changes only on clock edges. A disabled output is held low rather than left floating.

Top module: `sqw_gen`

## Requirements
- R1: After the asynchronous reset, the oscillator-on bit and the fast-clock enable are 0, the divider is zero and `sqw` is low. `sqw` stays low until a control write or a power-up event.
- R2: A cycle with `ctl_wr`=1 loads `ctl_osc_on` and `ctl_fast_en` into the two control bits. They take effect from the next clock edge.
- R3: A cycle with `pwr_up`=1 sets both control bits to 1 at the next edge, taking priority over a simultaneous write. `sqw` then toggles every clock cycle (period 2 cycles).
- R4: With main power good and the fast-clock enable at 1, `sqw` toggles every clock cycle whatever the values of `rate` and `sq_en`.
- R5: With main power good, the fast-clock enable at 0 and `sq_en`=1, a rate code c in 3..15 gives a period of 2^c clock cycles (32768 / 2^(c-1) Hz) at 50% duty.
- R6: Under the same conditions, rate code 1 gives a period of 256 cycles (256 Hz) and rate code 2 gives a period of 512 cycles (128 Hz), each at 50% duty.
- R7: With main power good and the fast-clock enable at 0, `sqw` is held low when `sq_en`=0 or when `rate`=0.
- R8: With `main_ok`=0, `sqw` toggles every cycle only if the fast-clock enable, `aux_bat_en` and `aux_ok` are all 1. Otherwise it is held low, including the case where `sq_en`=1 with a nonzero rate.
- R9: While the oscillator-on bit is 0, the divider is held at zero and `sqw` is low, even if the fast-clock enable is 1.
- R10: A change of `rate` while the output runs takes effect at the next clock edge. The first full period measured after the change has the new code's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the 32.768 kHz oscillator rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_up | input | 1 | Power-up event pulse; sets both control bits |
| ctl_wr | input | 1 | Write strobe for the control bits |
| ctl_osc_on | input | 1 | Oscillator-on value loaded by `ctl_wr` |
| ctl_fast_en | input | 1 | Fast-clock (32.768 kHz) enable value loaded by `ctl_wr` |
| rate | input | 4 | Rate code selecting the divider tap |
| sq_en | input | 1 | Square-wave enable for the programmed tap |
| main_ok | input | 1 | Main supply above the fail threshold |
| aux_bat_en | input | 1 | Auxiliary battery enable bit |
| aux_ok | input | 1 | Auxiliary supply present |
| sqw | output | 1 | Square-wave output |

## Verification
The bench measures whole periods and high times, so a tap mapped one stage off fails: it shows up as a period doubled or halved. Codes 1 and 2 are checked on their own, because they do not follow the general formula. A design that reused the 2^c rule for them would give 2 or 4 cycles. The override cases are also targeted. The fast-clock enable must win over a zero rate or a cleared enable, and a power-up event must win over a simultaneous clearing write. The aux-power gating must fall back to low whenever any one of its three conditions is missing, and an ordinary tap must never leak out on auxiliary power. A rate change from a very slow code to a fast one must show the fast period at once, so a design that waited for the old slow period to finish would fail.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

  localparam int unsigned DIV_STAGES_DEF = 15;
  localparam int unsigned RATE_W_DEF     = 4;
  // Stages used by the two low rate codes (256 Hz and 128 Hz)
  localparam int unsigned CODE1_STAGE    = 7;
  localparam int unsigned CODE2_STAGE    = 8;

  typedef struct packed {
    logic osc_on;
    logic fast_en;
  } sqw_ctl_t;

  // Divider stage selected by a nonzero rate code
  function automatic int unsigned tap_of_code(input int unsigned code);
    if (code == 1)      return CODE1_STAGE;
    else if (code == 2) return CODE2_STAGE;
    else                return code - 1;
  endfunction

endpackage

// File: rtl/sqw_ctl_reg.sv
module sqw_ctl_reg
  import sqw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pwr_up,
  input  logic     ctl_wr,
  input  logic     ctl_osc_on,
  input  logic     ctl_fast_en,
  output sqw_ctl_t ctl_q
);

  sqw_ctl_t ctl_d;
  logic     ctl_ce;

  assign ctl_ce = pwr_up | ctl_wr;

  always_comb begin
    ctl_d = ctl_q;
    if (pwr_up) begin
      ctl_d.osc_on  = 1'b1;
      ctl_d.fast_en = 1'b1;
    end else if (ctl_wr) begin
      ctl_d.osc_on  = ctl_osc_on;
      ctl_d.fast_en = ctl_fast_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_ce) begin
      ctl_q <= ctl_d;
    end
  end

endmodule

// File: rtl/sqw_divider.sv
module sqw_divider #(
  parameter int unsigned STAGES = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  output logic [STAGES-1:0] cnt
);

  logic [STAGES-1:0] carry;
  logic [STAGES-1:0] cnt_d;

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        assign carry[k] = run;
      end else begin : g_rest
        assign carry[k] = carry[k-1] & cnt[k-1];
      end
      assign cnt_d[k] = run & (cnt[k] ^ carry[k]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/sqw_tap_sel.sv
module sqw_tap_sel
  import sqw_pkg::*;
#(
  parameter int unsigned STAGES = 15,
  parameter int unsigned RATE_W = 4
) (
  input  logic [STAGES-1:0] cnt,
  input  logic [RATE_W-1:0] rate,
  output logic              tap
);

  localparam int unsigned IDX_W = (STAGES > 1) ? $clog2(STAGES) : 1;

  logic [IDX_W-1:0] idx;
  logic             idx_ok;

  always_comb begin
    idx    = IDX_W'(tap_of_code(int'(rate)));
    idx_ok = (rate != '0) && (int'(idx) < int'(STAGES));
    tap    = idx_ok ? cnt[idx] : 1'b0;
  end

endmodule

// File: rtl/sqw_out_stage.sv
module sqw_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_on,
  input  logic fast_en,
  input  logic sq_en,
  input  logic main_ok,
  input  logic aux_bat_en,
  input  logic aux_ok,
  input  logic fast_src,
  input  logic tap,
  output logic sqw
);

  logic sqw_d;
  logic aux_keep;

  assign aux_keep = fast_en & aux_bat_en & aux_ok;

  always_comb begin
    sqw_d = 1'b0;
    if (!osc_on) begin
      sqw_d = 1'b0;
    end else if (!main_ok) begin
      sqw_d = aux_keep & fast_src;
    end else if (fast_en) begin
      sqw_d = fast_src;
    end else if (sq_en) begin
      sqw_d = tap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sqw <= 1'b0;
    end else begin
      sqw <= sqw_d;
    end
  end

endmodule

// File: rtl/sqw_gen.sv
module sqw_gen
  import sqw_pkg::*;
#(
  parameter int unsigned DIV_STAGES = DIV_STAGES_DEF,
  parameter int unsigned RATE_W     = RATE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_up,
  input  logic              ctl_wr,
  input  logic              ctl_osc_on,
  input  logic              ctl_fast_en,
  input  logic [RATE_W-1:0] rate,
  input  logic              sq_en,
  input  logic              main_ok,
  input  logic              aux_bat_en,
  input  logic              aux_ok,
  output logic              sqw
);

  sqw_ctl_t              ctl_q;
  logic                  osc_on_q;
  logic                  fast_en_q;
  logic [DIV_STAGES-1:0] div_cnt;
  logic                  tap;

  sqw_ctl_reg u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_up      (pwr_up),
    .ctl_wr      (ctl_wr),
    .ctl_osc_on  (ctl_osc_on),
    .ctl_fast_en (ctl_fast_en),
    .ctl_q       (ctl_q)
  );

  assign osc_on_q  = ctl_q.osc_on;
  assign fast_en_q = ctl_q.fast_en;

  sqw_divider #(.STAGES(DIV_STAGES)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (osc_on_q),
    .cnt   (div_cnt)
  );

  sqw_tap_sel #(.STAGES(DIV_STAGES), .RATE_W(RATE_W)) u_tap (
    .cnt  (div_cnt),
    .rate (rate),
    .tap  (tap)
  );

  sqw_out_stage u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_on     (osc_on_q),
    .fast_en    (fast_en_q),
    .sq_en      (sq_en),
    .main_ok    (main_ok),
    .aux_bat_en (aux_bat_en),
    .aux_ok     (aux_ok),
    .fast_src   (div_cnt[0]),
    .tap        (tap),
    .sqw        (sqw)
  );

endmodule

// File: rtl/sqw_gen_chk.sv
module sqw_gen_chk #(
  parameter int unsigned STAGES = 15,
  parameter int unsigned RATE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_up,
  input logic [RATE_W-1:0] rate,
  input logic              sq_en,
  input logic              main_ok,
  input logic              aux_bat_en,
  input logic              aux_ok,
  input logic              osc_on_q,
  input logic              fast_en_q,
  input logic [STAGES-1:0] div_cnt,
  input logic              sqw
);

  logic fast_run;
  assign fast_run = osc_on_q & main_ok & fast_en_q;

  // R3: a power-up event sets both control bits
  a_r3_pwrup_sets: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_up |=> (osc_on_q && fast_en_q));

  // R4: the fast clock toggles the output every cycle
  a_r4_fast_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_run && $past(fast_run)) |=> (sqw != $past(sqw)));

  // R7: a zero rate or a cleared enable keeps the output low
  a_r7_tap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (main_ok && !fast_en_q && (!sq_en || rate == '0)) |=> !sqw);

  // R8: on auxiliary power only the full condition keeps it running
  a_r8_aux_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_ok && !(fast_en_q && aux_bat_en && aux_ok)) |=> !sqw);

  // R9: with the oscillator off the divider clears and the output is low
  a_r9_osc_off: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_on_q |=> (!sqw && div_cnt == '0));

endmodule

bind sqw_gen sqw_gen_chk #(.STAGES(DIV_STAGES), .RATE_W(RATE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_up     (pwr_up),
  .rate       (rate),
  .sq_en      (sq_en),
  .main_ok    (main_ok),
  .aux_bat_en (aux_bat_en),
  .aux_ok     (aux_ok),
  .osc_on_q   (osc_on_q),
  .fast_en_q  (fast_en_q),
  .div_cnt    (div_cnt),
  .sqw        (sqw)
);

// File: tb/sqw_gen_test.sv
`timescale 1ns/1ps
module sqw_gen_test;

  logic       clk;
  logic       rst_n;
  logic       pwr_up;
  logic       ctl_wr;
  logic       ctl_osc_on;
  logic       ctl_fast_en;
  logic [3:0] rate;
  logic       sq_en;
  logic       main_ok;
  logic       aux_bat_en;
  logic       aux_ok;
  logic       sqw;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sqw_gen uut (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .ctl_wr(ctl_wr),
    .ctl_osc_on(ctl_osc_on), .ctl_fast_en(ctl_fast_en), .rate(rate),
    .sq_en(sq_en), .main_ok(main_ok), .aux_bat_en(aux_bat_en),
    .aux_ok(aux_ok), .sqw(sqw)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ctl_write(input bit osc, input bit fast);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_osc_on = osc; ctl_fast_en = fast;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  // Waits for a rising edge, then times one full period and its high part
  task automatic measure(input int limit, output int per, output int hi);
    bit prev;
    bit found;
    per = 0; hi = 0; found = 0;
    prev = sqw;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (!prev && sqw) begin found = 1; break; end
      prev = sqw;
    end
    if (!found) return;
    prev = sqw;
    for (int i = 0; i < limit; i++) begin
      if (sqw) hi++;
      per++;
      @(negedge clk);
      if (!prev && sqw) return;
      prev = sqw;
    end
    per = 0;
  endtask

  task automatic expect_low(input int n, input string tag);
    int highs;
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sqw) highs++;
    end
    check(highs == 0, tag, highs, 0);
  endtask

  task automatic expect_period(input int limit, input int exp, input string tag);
    int per, hi;
    measure(limit, per, hi);
    check(per == exp, {tag, " period"}, per, exp);
    check(hi == exp / 2, {tag, " high time"}, hi, exp / 2);
  endtask

  task automatic t_reset;
    rate = 4'd3; sq_en = 1'b1; main_ok = 1'b1;
    check(sqw == 1'b0, "R1 reset output", int'(sqw), 0);
    expect_low(40, "R1 idle after reset");
  endtask

  task automatic t_ctl_write;
    rate = 4'd0; sq_en = 1'b0;
    ctl_write(1'b1, 1'b1);
    expect_period(20, 2, "R2 write osc+fast");
  endtask

  task automatic t_osc_off;
    ctl_write(1'b0, 1'b1);
    expect_low(40, "R9 osc off, fast on");
  endtask

  task automatic t_pwrup;
    @(negedge clk);
    pwr_up = 1'b1; ctl_wr = 1'b1; ctl_osc_on = 1'b0; ctl_fast_en = 1'b0;
    @(negedge clk);
    pwr_up = 1'b0; ctl_wr = 1'b0;
    expect_period(20, 2, "R3 power-up over write");
  endtask

  task automatic t_fast_override;
    rate = 4'd9; sq_en = 1'b1;
    expect_period(20, 2, "R4 fast overrides rate 9");
    rate = 4'd0; sq_en = 1'b0;
    expect_period(20, 2, "R4 fast with rate 0");
  endtask

  task automatic t_rates;
    ctl_write(1'b1, 1'b0);
    sq_en = 1'b1;
    rate = 4'd3;  expect_period(40, 8, "R5 code 3");
    rate = 4'd4;  expect_period(60, 16, "R5 code 4");
    rate = 4'd9;  expect_period(1200, 512, "R5 code 9");
    rate = 4'd1;  expect_period(600, 256, "R6 code 1");
    rate = 4'd2;  expect_period(1200, 512, "R6 code 2");
    rate = 4'd15; expect_period(70000, 32768, "R5 code 15");
  endtask

  task automatic t_quiet;
    rate = 4'd0; sq_en = 1'b1;
    expect_low(600, "R7 rate 0");
    rate = 4'd3; sq_en = 1'b0;
    expect_low(100, "R7 sq_en 0");
  endtask

  task automatic t_rate_change;
    sq_en = 1'b1; rate = 4'd15;
    repeat (300) @(negedge clk);
    rate = 4'd3;
    expect_period(40, 8, "R10 change 15 to 3");
  endtask

  task automatic t_aux;
    ctl_write(1'b1, 1'b1);
    main_ok = 1'b0; aux_bat_en = 1'b1; aux_ok = 1'b1;
    expect_period(20, 2, "R8 aux full condition");
    aux_ok = 1'b0;
    expect_low(40, "R8 aux supply missing");
    aux_ok = 1'b1; aux_bat_en = 1'b0;
    expect_low(40, "R8 aux disabled");
    aux_bat_en = 1'b1;
    ctl_write(1'b1, 1'b0);
    sq_en = 1'b1; rate = 4'd3;
    expect_low(60, "R8 tap blocked on aux");
    main_ok = 1'b1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; pwr_up = 1'b0; ctl_wr = 1'b0; ctl_osc_on = 1'b0;
    ctl_fast_en = 1'b0; rate = 4'd0; sq_en = 1'b0; main_ok = 1'b1;
    aux_bat_en = 1'b0; aux_ok = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_ctl_write;
    t_osc_off;
    t_pwrup;
    t_fast_override;
    t_rates;
    t_quiet;
    t_rate_change;
    t_aux;
    finish_run;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run;
  end

endmodule